// File: doc/BRIEF.md
# One-Hot State Six-Input Counter

This block adds six bits of a partial-product column: five of weight one and one of weight two. It produces a three-bit result whose bits weigh one, two and four. The sum is not formed by a binary adder tree. Three of the weight-one bits first build a 4-bit one-hot state whose hot position is their count, from 0 to 3. The remaining inputs then rotate that state: each weight-one input moves it by one position and the weight-two input moves it by two. A rotation that passes the top position counts as a wrap, and the wrap is the weight-four carry. The final one-hot state is encoded into the two low sum bits.

The block is purely combinational and has no carry-in or carry-out ports to its neighbours. A reduction column instantiates one of these and routes its three outputs to the columns of matching weight. Inverted copies of the weight-one sum and of the carry are provided for stages that need double-rail inputs. A parameter chooses whether those copies come from separate decode logic or from plain inversion.

Top module: `oh63Counter`

## Requirements
- R1: The first state is one-hot, with bit k hot exactly when k of cntIn1, cntIn2 and cntIn3 are 1. With stepA, stepB and stepDouble all 0, the outputs give sumW1 + 2·sumW2 = that count and carryW4 = 0.
- R2: For every input combination, sumW1 + 2·sumW2 + 4·carryW4 equals cntIn1 + cntIn2 + cntIn3 + stepA + stepB + 2·stepDouble.
- R3: stepDouble has weight two. With only stepDouble set, the result is sumW2 = 1, sumW1 = 0 and carryW4 = 0.
- R4: stepA and stepB each have weight one and behave the same. Setting either one alone, on top of any count, gives the same outputs.
- R5: The rotated state that drives the decode is one-hot for every input combination.
- R6: carryW4 is 1 exactly when the total of R2 is 4 or more. That is, it is 1 when the rotations carry the state past position 3.
- R7: {sumW2, sumW1} is the index of the hot bit of the final state. Bit 0 gives 00, bit 1 gives 01, bit 2 gives 10 and bit 3 gives 11.
- R8: sumW1N is always the inverse of sumW1, and carryW4N is always the inverse of carryW4.
- R9: All inputs at 0 give all three sum outputs at 0. All inputs at 1 give sumW1 = sumW2 = carryW4 = 1 (a total of 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cntIn1 | input | 1 | Weight-one bit that builds the first state |
| cntIn2 | input | 1 | Weight-one bit that builds the first state |
| cntIn3 | input | 1 | Weight-one bit that builds the first state |
| stepA | input | 1 | Weight-one bit, rotates the state by one |
| stepB | input | 1 | Weight-one bit, rotates the state by one |
| stepDouble | input | 1 | Weight-two bit, rotates the state by two |
| sumW1 | output | 1 | Result bit of weight one |
| sumW2 | output | 1 | Result bit of weight two |
| carryW4 | output | 1 | Result bit of weight four |
| sumW1N | output | 1 | Inverse of sumW1 |
| carryW4N | output | 1 | Inverse of carryW4 |

## Verification
The wrap into the carry can happen in the stage driven by stepA, by stepB or by stepDouble, and the same input vector also settles the low sum bits from the same rotation. The directed cases place the first state at count 3 with stepA set, so the wrap happens at the first rotation. They place it at count 2 with only stepDouble set, so the wrap happens at the last rotation. They also set every input, so the state wraps early and must not wrap again. In each case the carry and the low sum bits are judged together against the arithmetic total. The full sweep of all 64 vectors then checks every total from 0 to 7 and both complement outputs.

// File: rtl/oh63_pkg.sv
package oh63_pkg;
  // Number of positions in the one-hot state signal.
  localparam int STATE_W = 4;
  // Width of the binary index of the hot position.
  localparam int POS_W = $clog2(STATE_W);
  // Number of bits that build the first state.
  localparam int CONV_N = 3;
  // Number of rotation stages after the first state.
  localparam int ROT_N = 3;

  typedef logic [STATE_W-1:0] ohState_t;
  typedef logic [POS_W-1:0] ohPos_t;

  // Enable strobes from the control part to the rotation stages.
  typedef struct packed {
    logic rotA;
    logic rotB;
    logic rotDouble;
  } rotStrobe_t;

  localparam ohState_t STATE_ZERO = ohState_t'(1);
endpackage

// File: rtl/oh63RotStage.sv
module oh63RotStage
  import oh63_pkg::*;
#(
  parameter int STEP = 1
) (
  input  ohState_t stIn,
  input  logic     en,
  output ohState_t stOut,
  output logic     wrapOut
);
  localparam int DBL_W = 2 * STATE_W;

  logic [DBL_W-1:0] dbl;
  ohState_t rotated;

  always_comb begin
    dbl     = {stIn, stIn};
    rotated = dbl[DBL_W-1-STEP -: STATE_W];
    stOut   = en ? rotated : stIn;
    // A hot bit in the top STEP positions passes position STATE_W-1.
    wrapOut = en & (|stIn[STATE_W-1 -: STEP]);
  end
endmodule

// File: rtl/oh63Ctrl.sv
module oh63Ctrl
  import oh63_pkg::*;
(
  input  logic       stepA,
  input  logic       stepB,
  input  logic       stepDouble,
  output rotStrobe_t strobe
);
  always_comb begin
    strobe.rotA      = stepA;
    strobe.rotB      = stepB;
    strobe.rotDouble = stepDouble;
  end
endmodule

// File: rtl/oh63Datapath.sv
module oh63Datapath
  import oh63_pkg::*;
#(
  parameter bit SPLIT_DECODE = 1'b1
) (
  input  logic              cntIn1,
  input  logic              cntIn2,
  input  logic              cntIn3,
  input  rotStrobe_t        strobe,
  output ohState_t          xState,
  output ohState_t          mState,
  output logic [CONV_N-1:0] convWrap,
  output logic [ROT_N-1:0]  stageWrap,
  output logic              sumW1,
  output logic              sumW2,
  output logic              carryW4,
  output logic              sumW1N,
  output logic              carryW4N
);
  localparam int ROT_STEP [ROT_N] = '{1, 1, 2};

  ohState_t convChain [CONV_N+1];
  ohState_t rotChain  [ROT_N+1];
  logic [CONV_N-1:0] convEn;
  logic [ROT_N-1:0]  rotEn;
  ohPos_t mPos;

  assign convEn = {cntIn3, cntIn2, cntIn1};
  assign rotEn  = {strobe.rotDouble, strobe.rotB, strobe.rotA};
  assign convChain[0] = STATE_ZERO;

  // Converter: each counted bit moves the hot position up by one.
  for (genvar g = 0; g < CONV_N; g++) begin : g_conv
    oh63RotStage #(.STEP(1)) conv_i (
      .stIn   (convChain[g]),
      .en     (convEn[g]),
      .stOut  (convChain[g+1]),
      .wrapOut(convWrap[g])
    );
  end

  assign xState      = convChain[CONV_N];
  assign rotChain[0] = xState;

  // Rotation stages: single-weight inputs first, then the double step.
  for (genvar g = 0; g < ROT_N; g++) begin : g_rot
    oh63RotStage #(.STEP(ROT_STEP[g])) rot_i (
      .stIn   (rotChain[g]),
      .en     (rotEn[g]),
      .stOut  (rotChain[g+1]),
      .wrapOut(stageWrap[g])
    );
  end

  assign mState = rotChain[ROT_N];

  // Decode the one-hot position into its binary index.
  always_comb begin
    mPos = '0;
    for (int k = 0; k < STATE_W; k++) begin
      if (mState[k]) mPos = mPos | ohPos_t'(k);
    end
  end

  assign sumW1   = mPos[0];
  assign sumW2   = mPos[1];
  assign carryW4 = |stageWrap;

  if (SPLIT_DECODE) begin : g_split
    // The even positions give a zero low bit, and no wrap gives no carry.
    assign sumW1N   = mState[0] | mState[2];
    assign carryW4N = ~(|stageWrap);
  end else begin : g_inv
    assign sumW1N   = ~sumW1;
    assign carryW4N = ~carryW4;
  end
endmodule

// File: rtl/oh63Counter.sv
module oh63Counter
  import oh63_pkg::*;
#(
  parameter bit SPLIT_DECODE = 1'b1
) (
  input  logic cntIn1,
  input  logic cntIn2,
  input  logic cntIn3,
  input  logic stepA,
  input  logic stepB,
  input  logic stepDouble,
  output logic sumW1,
  output logic sumW2,
  output logic carryW4,
  output logic sumW1N,
  output logic carryW4N
);
  rotStrobe_t strobe;
  ohState_t xState;
  ohState_t mState;
  logic [CONV_N-1:0] convWrap;
  logic [ROT_N-1:0]  stageWrap;

  oh63Ctrl ctrl_i (
    .stepA     (stepA),
    .stepB     (stepB),
    .stepDouble(stepDouble),
    .strobe    (strobe)
  );

  oh63Datapath #(.SPLIT_DECODE(SPLIT_DECODE)) dp_i (
    .cntIn1   (cntIn1),
    .cntIn2   (cntIn2),
    .cntIn3   (cntIn3),
    .strobe   (strobe),
    .xState   (xState),
    .mState   (mState),
    .convWrap (convWrap),
    .stageWrap(stageWrap),
    .sumW1    (sumW1),
    .sumW2    (sumW2),
    .carryW4  (carryW4),
    .sumW1N   (sumW1N),
    .carryW4N (carryW4N)
  );
endmodule

// File: rtl/oh63Checker.sv
module oh63Checker
  import oh63_pkg::*;
(
  input logic              cntIn1,
  input logic              cntIn2,
  input logic              cntIn3,
  input logic              stepA,
  input logic              stepB,
  input logic              stepDouble,
  input logic              sumW1,
  input logic              sumW2,
  input logic              carryW4,
  input logic              sumW1N,
  input logic              carryW4N,
  input ohState_t          xState,
  input ohState_t          mState,
  input logic [CONV_N-1:0] convWrap,
  input logic [ROT_N-1:0]  stageWrap
);
  logic [3:0] inTotal;
  logic [3:0] outTotal;
  logic [1:0] xCount;

  always_comb begin
    xCount   = 2'(cntIn1) + 2'(cntIn2) + 2'(cntIn3);
    inTotal  = 4'(xCount) + 4'(stepA) + 4'(stepB) + 4'({stepDouble, 1'b0});
    outTotal = 4'(sumW1) + 4'({sumW2, 1'b0}) + 4'({carryW4, 2'b00});
  end

  always_comb begin
    assert_x_onehot_R1: assert ($countones(xState) == 1 && xState[xCount]);
    assert_conv_nowrap_R1: assert (convWrap == '0);
    assert_sum_identity_R2: assert (outTotal == inTotal);
    assert_m_onehot_R5: assert ($countones(mState) == 1);
    assert_single_wrap_R6: assert ($countones(stageWrap) <= 1 && carryW4 == (inTotal >= 4'd4));
    assert_decode_index_R7: assert (mState[{sumW2, sumW1}]);
    assert_complements_R8: assert (sumW1N == !sumW1 && carryW4N == !carryW4);
  end
endmodule

bind oh63Counter oh63Checker chk_i (
  .cntIn1    (cntIn1),
  .cntIn2    (cntIn2),
  .cntIn3    (cntIn3),
  .stepA     (stepA),
  .stepB     (stepB),
  .stepDouble(stepDouble),
  .sumW1     (sumW1),
  .sumW2     (sumW2),
  .carryW4   (carryW4),
  .sumW1N    (sumW1N),
  .carryW4N  (carryW4N),
  .xState    (xState),
  .mState    (mState),
  .convWrap  (convWrap),
  .stageWrap (stageWrap)
);

// File: tb/oh63Counter_tb.sv
module oh63Counter_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntIn1 = 1'b0, cntIn2 = 1'b0, cntIn3 = 1'b0;
  logic stepA = 1'b0, stepB = 1'b0, stepDouble = 1'b0;
  logic sumW1, sumW2, carryW4, sumW1N, carryW4N;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  oh63Counter dut_i (
    .cntIn1    (cntIn1),
    .cntIn2    (cntIn2),
    .cntIn3    (cntIn3),
    .stepA     (stepA),
    .stepB     (stepB),
    .stepDouble(stepDouble),
    .sumW1     (sumW1),
    .sumW2     (sumW2),
    .carryW4   (carryW4),
    .sumW1N    (sumW1N),
    .carryW4N  (carryW4N)
  );

  // Drive after a rising edge, sample at the following falling edge.
  task automatic applyVec(input logic [5:0] v);
    @(posedge clk);
    {stepDouble, stepB, stepA, cntIn3, cntIn2, cntIn1} <= v;
    @(negedge clk);
  endtask

  task automatic checkVal(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int outSum();
    return int'(sumW1) + 2 * int'(sumW2) + 4 * int'(carryW4);
  endfunction

  function automatic int vecSum(input logic [5:0] v);
    return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]) + int'(v[4]) + 2 * int'(v[5]);
  endfunction

  task automatic testResetState();
    applyVec(6'b000000);
    checkVal("R9 zero in sum", outSum(), 0);
    checkVal("R8 zero in sumW1N", int'(sumW1N), 1);
    checkVal("R8 zero in carryW4N", int'(carryW4N), 1);
  endtask

  task automatic testConverter();
    for (int v = 0; v < 8; v++) begin
      applyVec(6'(v));
      checkVal("R1 count", int'(sumW1) + 2 * int'(sumW2), $countones(v));
      checkVal("R1 no carry", int'(carryW4), 0);
    end
  endtask

  task automatic testWeights();
    applyVec(6'b100000);
    checkVal("R3 sumW2", int'(sumW2), 1);
    checkVal("R3 sumW1", int'(sumW1), 0);
    checkVal("R3 carryW4", int'(carryW4), 0);
    for (int c = 0; c < 8; c++) begin
      int resA;
      applyVec(6'(c) | 6'b001000);
      resA = outSum();
      applyVec(6'(c) | 6'b010000);
      checkVal("R4 stepB equals stepA", outSum(), resA);
      checkVal("R4 weight one", resA, $countones(c) + 1);
    end
  endtask

  task automatic testWrapPlacement();
    // Wrap in the first rotation stage: count 3 plus stepA.
    applyVec(6'b001111);
    checkVal("R6 early wrap carry", int'(carryW4), 1);
    checkVal("R7 early wrap index", int'(sumW1) + 2 * int'(sumW2), 0);
    // Wrap in the double stage: count 2 plus stepDouble.
    applyVec(6'b100011);
    checkVal("R6 late wrap carry", int'(carryW4), 1);
    checkVal("R7 late wrap index", int'(sumW1) + 2 * int'(sumW2), 0);
    // Count 1 plus stepDouble reaches position 3 without wrapping.
    applyVec(6'b100001);
    checkVal("R6 top no wrap", int'(carryW4), 0);
    checkVal("R7 top index", int'(sumW1) + 2 * int'(sumW2), 3);
  endtask

  task automatic testExtremes();
    applyVec(6'b111111);
    checkVal("R9 all ones sumW1", int'(sumW1), 1);
    checkVal("R9 all ones sumW2", int'(sumW2), 1);
    checkVal("R9 all ones carryW4", int'(carryW4), 1);
  endtask

  task automatic testExhaustive();
    for (int v = 0; v < 64; v++) begin
      int tot;
      applyVec(6'(v));
      tot = vecSum(6'(v));
      checkVal("R2 identity", outSum(), tot);
      checkVal("R5 R7 low bits", int'(sumW1) + 2 * int'(sumW2), tot % 4);
      checkVal("R6 carry", int'(carryW4), (tot >= 4) ? 1 : 0);
      checkVal("R8 sumW1N", int'(sumW1N), int'(!sumW1));
      checkVal("R8 carryW4N", int'(carryW4N), int'(!carryW4));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN <= 1'b1;
    testResetState();
    testConverter();
    testWeights();
    testWrapPlacement();
    testExtremes();
    testExhaustive();
    done = 1'b1;
  end

  initial begin
    for (int n = 0; n < WATCHDOG_CYCLES; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule